// File: doc/BRIEF.md
# Time-Tagged Input Capture FIFO

This block watches four event inputs and records their transitions, each stamped with a free-running 16-bit timer. The timer advances once every `PRESCALE` clocks. That interval is the capture resolution. Each input passes through a two-flop synchroniser and an edge detector. Each pin has its own edge choice: rising, falling, both, or none.

All events seen while the timer holds one value are merged into a single entry. The entry carries an OR of the per-pin event flags and the timer value shared by those events. It is committed on the last clock of that timer period.

Committed entries land in a holding register. A small FIFO sits behind the holding register. The first entry into an empty structure goes straight into the holding register. Later entries queue in the FIFO, oldest first. A consumer reads the holding register by pulsing `rd_en`. The register then refills from the FIFO on the next clock. When the FIFO is full, new entries are dropped and a sticky overflow flag is raised.

Top module: `evcap_unit`

## Requirements
- R1: After a synchronous active-low reset, `hold_valid`, `fifo_count`, `overflow` and `timer_now` are all 0.
- R2: `timer_now` increments by one every `PRESCALE` (default 8) clocks. After n rising clock edges since reset release, it equals n / PRESCALE (integer division).
- R3: For pin i, bit `edge_sel[2i]` enables rising-edge events and bit `edge_sel[2i+1]` enables falling-edge events. With both bits 0, the pin never produces an entry.
- R4: A pin change driven between clock edges k-1 and k is detected two clocks later, in the cycle between edges k+1 and k+2. It is tagged with the timer value of that cycle. So a change driven in the first six cycles of an 8-clock timer period lands in that period, and a change in the seventh cycle lands in the next period.
- R5: All events detected during one timer period form exactly one entry. Its mask bit i (bit 0 = pin 0) is set when pin i had an event, and its tag is that period's timer value. The entry becomes visible at the clock edge where the timer advances.
- R6: An entry committed while the holding register and the FIFO are both empty goes directly into the holding register, and `fifo_count` stays 0.
- R7: Otherwise, committed entries enter the FIFO and later reach the holding register in commit order.
- R8: `rd_en` while `hold_valid` is 1 clears `hold_valid` at the next edge. If the FIFO is non-empty, the oldest entry is loaded one edge later and `fifo_count` decreases by one. `rd_en` while `hold_valid` is 0 has no effect.
- R9: With `DEPTH` (default 7) entries queued and the holding register occupied, a further entry is dropped. In that case `overflow` is set and stays set until reset, and the queued entries are unchanged.
- R10: A timer period with no detected events produces no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 4 | Asynchronous event inputs |
| edge_sel | input | 8 | Per-pin edge enables: bit 2i rising, bit 2i+1 falling |
| rd_en | input | 1 | Consume the holding register |
| hold_valid | output | 1 | Holding register contains an entry |
| hold_mask | output | 4 | Pin-event mask of the held entry |
| hold_tag | output | 16 | Time tag of the held entry |
| fifo_count | output | 3 | Entries waiting in the FIFO |
| overflow | output | 1 | Sticky: an entry was dropped |
| timer_now | output | 16 | Free-running time-tag counter |

## Verification
The assertions assume that `rd_en` is pulsed for a single clock. They also assume `edge_sel` only changes while the synchroniser holds a settled value. The stimulus keeps to both by driving inputs on falling edges, one change per step. It waits for each entry before reading it and leaves pins still while `edge_sel` is rewritten. Pin changes are placed at chosen offsets inside a timer period, counted from the observed timer step, so the bench knows which tag each event must carry.

// File: rtl/evcap_pkg.sv
// evcap_pkg: shared widths and the capture entry type.
// Assumes a fixed pin count and tag width for the whole unit.
package evcap_pkg;
    localparam int unsigned EV_PINS = 4;
    localparam int unsigned TAG_W   = 16;

    typedef struct packed {
        logic [EV_PINS-1:0] mask;
        logic [TAG_W-1:0]   tag;
    } evcap_entry_t;
endpackage

// File: rtl/evcap_edge.sv
// evcap_edge: two-flop synchroniser plus per-pin edge detector.
// Assumes pin inputs are asynchronous and edge_sel is quasi-static.
module evcap_edge #(
    parameter int unsigned NPIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [2*NPIN-1:0] edge_sel,
    output logic [NPIN-1:0]   ev
);
    logic [NPIN-1:0] sync1, sync2, prev;

    // Synchronise the pins and keep the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // One edge qualifier per pin, selected by two enable bits.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign ev[i] = (sync2[i] & ~prev[i] & edge_sel[2*i])
                     | (~sync2[i] & prev[i] & edge_sel[2*i+1]);
    end
endmodule

// File: rtl/evcap_window.sv
// evcap_window: prescaled time-tag counter and per-period event merger.
// Assumes PRESCALE >= 2; an entry is offered on the period's last clock.
module evcap_window
    import evcap_pkg::*;
#(
    parameter int unsigned PRESCALE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EV_PINS-1:0] ev,
    output logic [TAG_W-1:0]   timer,
    output logic               commit_vld,
    output evcap_entry_t       commit_entry
);
    localparam int unsigned PW = $clog2(PRESCALE);

    logic [PW-1:0]      pre;
    logic [EV_PINS-1:0] acc_mask;
    logic [EV_PINS-1:0] win_mask;
    logic               last;

    assign last     = (pre == PW'(PRESCALE-1));
    assign win_mask = acc_mask | ev;

    // Prescaler and timer: the timer steps on the period's last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre   <= '0;
            timer <= '0;
        end else if (last) begin
            pre   <= '0;
            timer <= timer + TAG_W'(1);
        end else begin
            pre   <= pre + PW'(1);
        end
    end

    // Accumulate events of the current period; clear when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_mask <= '0;
        else if (last) acc_mask <= '0;
        else           acc_mask <= win_mask;
    end

    assign commit_vld        = last && (win_mask != '0);
    assign commit_entry.mask = win_mask;
    assign commit_entry.tag  = timer;
endmodule

// File: rtl/evcap_store.sv
// evcap_store: holding register fronting a circular FIFO.
// Assumes rd_en is honoured only while the holding register is valid.
module evcap_store
    import evcap_pkg::*;
#(
    parameter int unsigned DEPTH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  evcap_entry_t               push_entry,
    input  logic                       rd_en,
    output logic                       hold_valid,
    output evcap_entry_t               hold_entry,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       overflow
);
    localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNTW = $clog2(DEPTH+1);

    evcap_entry_t    mem [DEPTH];
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic            fifo_empty, fifo_full, pop, to_hold, fifo_wr, drop;

    function automatic logic [PTRW-1:0] ptr_next(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH-1)) ? '0 : p + PTRW'(1);
    endfunction

    assign fifo_empty = (count == '0);
    assign fifo_full  = (count == CNTW'(DEPTH));
    assign pop        = !hold_valid && !fifo_empty;
    assign to_hold    = push && !hold_valid && fifo_empty;
    assign fifo_wr    = push && !to_hold && (!fifo_full || pop);
    assign drop       = push && !to_hold && fifo_full && !pop;

    // FIFO storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (fifo_wr) mem[wr_ptr] <= push_entry;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (fifo_wr) wr_ptr <= ptr_next(wr_ptr);
            if (pop)     rd_ptr <= ptr_next(rd_ptr);
            case ({fifo_wr, pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
            if (drop) overflow <= 1'b1;
        end
    end

    // Holding register: refill from FIFO, bypass when empty, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_entry <= '0;
        end else if (pop) begin
            hold_valid <= 1'b1;
            hold_entry <= mem[rd_ptr];
        end else if (to_hold) begin
            hold_valid <= 1'b1;
            hold_entry <= push_entry;
        end else if (rd_en && hold_valid) begin
            hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/evcap_unit.sv
// evcap_unit: time-tagged input capture with holding register and FIFO.
// Assumes a single clock domain; pins are synchronised internally.
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int unsigned DEPTH    = 7,
    parameter int unsigned PRESCALE = 8,
    localparam int unsigned CNTW    = $clog2(DEPTH+1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EV_PINS-1:0]   pin_in,
    input  logic [2*EV_PINS-1:0] edge_sel,
    input  logic                 rd_en,
    output logic                 hold_valid,
    output logic [EV_PINS-1:0]   hold_mask,
    output logic [TAG_W-1:0]     hold_tag,
    output logic [CNTW-1:0]      fifo_count,
    output logic                 overflow,
    output logic [TAG_W-1:0]     timer_now
);
    logic [EV_PINS-1:0] ev;
    logic               commit_vld;
    evcap_entry_t       commit_entry;
    evcap_entry_t       hold_entry;

    evcap_edge #(.NPIN(EV_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .edge_sel(edge_sel), .ev(ev)
    );

    evcap_window #(.PRESCALE(PRESCALE)) u_win (
        .clk(clk), .rst_n(rst_n), .ev(ev), .timer(timer_now),
        .commit_vld(commit_vld), .commit_entry(commit_entry)
    );

    evcap_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(commit_vld),
        .push_entry(commit_entry), .rd_en(rd_en),
        .hold_valid(hold_valid), .hold_entry(hold_entry),
        .count(fifo_count), .overflow(overflow)
    );

    assign hold_mask = hold_entry.mask;
    assign hold_tag  = hold_entry.tag;
endmodule

// File: rtl/evcap_unit_chk.sv
// evcap_unit_chk: protocol and state properties of evcap_unit, bound in.
// Assumes synchronous reset held for at least one clock edge.
module evcap_unit_chk #(
    parameter int unsigned DEPTH = 7,
    parameter int unsigned CNTW  = 3,
    parameter int unsigned NPIN  = 4,
    parameter int unsigned TW    = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic            hold_valid,
    input logic [NPIN-1:0] hold_mask,
    input logic [CNTW-1:0] fifo_count,
    input logic            overflow,
    input logic [TW-1:0]   timer_now,
    input logic            commit_vld
);
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_now == $past(timer_now)) || (timer_now == $past(timer_now) + TW'(1))); // R2
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid |-> (hold_mask != '0)); // R5
    AST_FIRST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !hold_valid && fifo_count == '0) |=> (hold_valid && fifo_count == '0)); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hold_valid) |=> !hold_valid); // R8
    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_valid && fifo_count != '0) |=> hold_valid); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNTW'(DEPTH)); // R9
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && hold_valid && fifo_count == CNTW'(DEPTH)) |=> overflow); // R9
endmodule

bind evcap_unit evcap_unit_chk #(
    .DEPTH(DEPTH), .CNTW(CNTW), .NPIN(evcap_pkg::EV_PINS), .TW(evcap_pkg::TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hold_valid(hold_valid),
    .hold_mask(hold_mask), .fifo_count(fifo_count), .overflow(overflow),
    .timer_now(timer_now), .commit_vld(commit_vld)
);

// File: tb/evcap_unit_test.sv
module evcap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = '0;
    logic [7:0]  edge_sel = '0;
    logic        rd_en = 1'b0;
    logic        hold_valid;
    logic [3:0]  hold_mask;
    logic [15:0] hold_tag;
    logic [2:0]  fifo_count;
    logic        overflow;
    logic [15:0] timer_now;

    int n_tests = 0;
    int n_fail  = 0;

    evcap_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(edge_sel),
        .rd_en(rd_en), .hold_valid(hold_valid), .hold_mask(hold_mask),
        .hold_tag(hold_tag), .fifo_count(fifo_count), .overflow(overflow),
        .timer_now(timer_now)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait until the timer steps; returns at j=0 of the new period.
    task automatic next_period();
        logic [15:0] t;
        t = timer_now;
        while (timer_now == t) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] t0;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 hold_valid", 32'(hold_valid), 0);
        chk("R1 fifo_count", 32'(fifo_count), 0);
        chk("R1 overflow", 32'(overflow), 0);
        chk("R1 timer", 32'(timer_now), 0);
        // R2: timer value after n edges since release
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk);
            chk("R2 timer", 32'(timer_now), 32'(n / 8));
        end

        // R3/R5/R6/R8: per-pin, per-selection sweep of rising and falling edges
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                edge_sel = 8'(s) << (2 * p);
                for (int dir = 0; dir < 2; dir++) begin
                    next_period();
                    t0 = timer_now;
                    pin_in[p] = (dir == 0);
                    next_period();
                    if (((s >> dir) & 1) == 1) begin
                        chk("R3 valid", 32'(hold_valid), 1);
                        chk("R5 mask", 32'(hold_mask), 32'(1 << p));
                        chk("R5 tag", 32'(hold_tag), 32'(t0));
                        chk("R6 direct", 32'(fifo_count), 0);
                        pulse_read();
                        chk("R8 cleared", 32'(hold_valid), 0);
                    end else begin
                        chk("R3 ignored", 32'(hold_valid), 0);
                    end
                end
            end
        end

        // R5: merging within one period
        edge_sel = 8'hFF;
        next_period();
        t0 = timer_now;
        pin_in[0] = 1'b1; pin_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        pin_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        pin_in[0] = 1'b0;
        next_period();
        chk("R5 merged mask", 32'(hold_mask), 32'h7);
        chk("R5 merged tag", 32'(hold_tag), 32'(t0));
        chk("R5 single entry", 32'(fifo_count), 0);
        pulse_read();

        // R4/R10: change in the seventh cycle lands in the next period
        next_period();
        t0 = timer_now;
        repeat (6) @(negedge clk);
        pin_in[3] = 1'b1;
        next_period();
        chk("R4 R10 no entry yet", 32'(hold_valid), 0);
        next_period();
        chk("R4 late valid", 32'(hold_valid), 1);
        chk("R4 late tag", 32'(hold_tag), 32'(t0 + 16'd1));
        chk("R4 late mask", 32'(hold_mask), 32'h8);
        pulse_read();

        // R7/R9: fill holding register and FIFO, then overflow once
        next_period();
        t0 = timer_now;
        for (int k = 0; k < 9; k++) begin
            pin_in[k % 4] = ~pin_in[k % 4];
            next_period();
        end
        chk("R9 count full", 32'(fifo_count), 7);
        chk("R9 overflow set", 32'(overflow), 1);
        chk("R7 head mask", 32'(hold_mask), 32'h1);
        chk("R7 head tag", 32'(hold_tag), 32'(t0));
        for (int k = 1; k < 8; k++) begin
            pulse_read();
            chk("R8 clear before refill", 32'(hold_valid), 0);
            @(negedge clk);
            chk("R7 order valid", 32'(hold_valid), 1);
            chk("R7 order mask", 32'(hold_mask), 32'(1 << (k % 4)));
            chk("R7 order tag", 32'(hold_tag), 32'(t0 + 16'(k)));
            chk("R8 count", 32'(fifo_count), 32'(7 - k));
        end
        pulse_read();
        @(negedge clk);
        chk("R9 dropped entry absent", 32'(hold_valid), 0);
        chk("R9 overflow sticky", 32'(overflow), 1);
        // R8: read while empty has no effect
        pulse_read();
        @(negedge clk);
        chk("R8 idle read valid", 32'(hold_valid), 0);
        chk("R8 idle read count", 32'(fifo_count), 0);
        // R1/R9: reset clears overflow
        do_reset();
        chk("R1 R9 overflow reset", 32'(overflow), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule